// File: doc/BRIEF.md
# Five-Stage Pipeline Hazard Controller

This block is the hazard control for an in-order integer pipeline with five stages: fetch, decode with register read, execute, memory and writeback. Each cycle the decode stage presents the register fields and decoded control bits of the instruction it holds. The controller carries those control bits through its own execute, memory and writeback stage registers. From that state it drives the operand selects for the two ALU inputs and the stall controls for the fetch side.

A result that has been computed but not yet written is routed to the ALU input that needs it. The route is taken from the execute/memory register when the producer is one stage ahead, and from the memory/writeback register when it is two stages ahead. A load cannot supply its data one stage ahead, so a consumer right behind a load costs one bubble. A branch waits in place until execute has resolved it, which costs two fetch cycles. The register file writes before it reads within a cycle, so decode never needs a bypass from writeback.

No data stream passes through the block, so it has no valid/ready pair. Decode offers one instruction per cycle, qualified by `id_valid`. The controller applies back-pressure only through its outputs. `pc_hold` and `ifid_hold` freeze the front end, `ifid_squash` empties the fetch/decode register, and `idex_bubble` replaces the execute entry with an empty slot. The surrounding pipeline must obey these outputs in the same cycle.

Top module: `hazard_ctrl`

## Requirements
- R1: The control fields of an instruction that decode passes into execute appear on `mem_we` one cycle later and on `wb_wen`/`wb_rd` two cycles later, with no change.
- R2: Select encoding: 0 means the operand read in decode, 1 means the memory/writeback register, 2 means the execute/memory register. A used source selects 2 when the execute/memory instruction writes a register whose number equals that source.
- R3: A used source selects 1 when only the memory/writeback instruction writes the matching register.
- R4: When both later stages write the same matching register, the select is 2, so the more recent result wins.
- R5: Register 0 never causes forwarding and never causes a load-use stall, and writes to it have no effect.
- R6: If execute holds a load whose nonzero destination matches a used source of the decode instruction, `pc_hold`, `ifid_hold` and `idex_bubble` are high for exactly one cycle. The consumer then takes the load data through select 1.
- R7: A bubble enters execute with its register-write and store controls cleared, so it writes no register and no data memory.
- R8: A branch in decode, and the same branch one cycle later in execute, each raise `pc_hold` and `ifid_squash` with `ifid_hold` low. That is two lost fetch cycles per branch.
- R9: When a load-use stall and a branch in decode coincide, the hold wins: `ifid_squash` stays low that cycle.
- R10: A program of N instructions with L load-use pairs and B branches that are followed by an instruction retires in N+4+L+2B cycles. Its final registers equal those of sequential execution.
- R11: While reset is asserted, all stall outputs, both selects, `mem_we` and `wb_wen` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| id_valid | input | 1 | Decode holds a real instruction |
| id_rs1 | input | AW | First source register number |
| id_rs2 | input | AW | Second source register number |
| id_use_rs1 | input | 1 | Instruction reads the first source |
| id_use_rs2 | input | 1 | Instruction reads the second source |
| id_rd | input | AW | Destination register number |
| id_wen | input | 1 | Instruction writes a register |
| id_load | input | 1 | Instruction reads data memory |
| id_store | input | 1 | Instruction writes data memory |
| id_branch | input | 1 | Instruction is a branch |
| ex_fwd_a | output | 2 | Select for ALU input A |
| ex_fwd_b | output | 2 | Select for ALU input B |
| pc_hold | output | 1 | Keep the program counter |
| ifid_hold | output | 1 | Keep the fetch/decode register |
| ifid_squash | output | 1 | Load an empty slot into fetch/decode |
| idex_bubble | output | 1 | Load an empty slot into decode/execute |
| mem_we | output | 1 | Data memory write for the memory-stage instruction |
| wb_wen | output | 1 | Register write for the writeback instruction |
| wb_rd | output | AW | Register number written at writeback |

## Verification
The checker watches several cycle-local rules on every clock. A bubble never lasts two cycles in a row and always comes with both holds. A bubble always leaves execute with writes cleared. Register 0 is never forwarded. A load in the memory stage is never chosen as a forwarding source. A branch in execute always squashes. Hold and squash never coincide. The rest can only be shown by the bench's scenarios: that the selects actually deliver correct operands, that the nearer result wins, and the exact cycle count of stalls over whole programs. The bench shows these by running a register-level data path on the controller's outputs and comparing final registers and retirement time with sequential execution.

// File: rtl/hz_pkg.sv
package hz_pkg;
  typedef enum logic [1:0] {
    SRC_RF  = 2'd0,
    SRC_WB  = 2'd1,
    SRC_MEM = 2'd2
  } fwd_src_e;
endpackage

// File: rtl/hz_ctl_pipe.sv
// Carries decoded control fields from decode through execute, memory and writeback.
module hz_ctl_pipe #(
  parameter int AW = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bubble,
  input  logic          id_valid,
  input  logic [AW-1:0] id_rs1,
  input  logic [AW-1:0] id_rs2,
  input  logic          id_use1,
  input  logic          id_use2,
  input  logic [AW-1:0] id_rd,
  input  logic          id_wen,
  input  logic          id_load,
  input  logic          id_store,
  input  logic          id_branch,
  output logic          ex_valid,
  output logic [AW-1:0] ex_rs1,
  output logic [AW-1:0] ex_rs2,
  output logic          ex_use1,
  output logic          ex_use2,
  output logic [AW-1:0] ex_rd,
  output logic          ex_wen,
  output logic          ex_load,
  output logic          ex_store,
  output logic          ex_branch,
  output logic [AW-1:0] mem_rd,
  output logic          mem_wen,
  output logic          mem_load,
  output logic          mem_store,
  output logic [AW-1:0] wb_rd,
  output logic          wb_wen
);
  typedef struct packed {
    logic          valid;
    logic [AW-1:0] rs1;
    logic [AW-1:0] rs2;
    logic          use1;
    logic          use2;
    logic [AW-1:0] rd;
    logic          wen;
    logic          load;
    logic          store;
    logic          branch;
  } ex_ctl_t;

  typedef struct packed {
    logic [AW-1:0] rd;
    logic          wen;
    logic          load;
    logic          store;
  } late_ctl_t;

  ex_ctl_t   ex_q, ex_d;
  late_ctl_t mem_q;

  always_comb begin
    ex_d = '0;
    if (id_valid && !bubble) begin
      ex_d.valid  = 1'b1;
      ex_d.rs1    = id_rs1;
      ex_d.rs2    = id_rs2;
      ex_d.use1   = id_use1;
      ex_d.use2   = id_use2;
      ex_d.rd     = id_rd;
      ex_d.wen    = id_wen;
      ex_d.load   = id_load;
      ex_d.store  = id_store;
      ex_d.branch = id_branch;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ex_q   <= '0;
      mem_q  <= '0;
      wb_rd  <= '0;
      wb_wen <= 1'b0;
    end else begin
      ex_q       <= ex_d;
      mem_q.rd   <= ex_q.rd;
      mem_q.wen  <= ex_q.valid && ex_q.wen;
      mem_q.load <= ex_q.valid && ex_q.load;
      mem_q.store <= ex_q.valid && ex_q.store;
      wb_rd      <= mem_q.rd;
      wb_wen     <= mem_q.wen;
    end
  end

  assign ex_valid  = ex_q.valid;
  assign ex_rs1    = ex_q.rs1;
  assign ex_rs2    = ex_q.rs2;
  assign ex_use1   = ex_q.use1;
  assign ex_use2   = ex_q.use2;
  assign ex_rd     = ex_q.rd;
  assign ex_wen    = ex_q.wen;
  assign ex_load   = ex_q.load;
  assign ex_store  = ex_q.store;
  assign ex_branch = ex_q.branch;
  assign mem_rd    = mem_q.rd;
  assign mem_wen   = mem_q.wen;
  assign mem_load  = mem_q.load;
  assign mem_store = mem_q.store;
endmodule

// File: rtl/hz_fwd_sel.sv
// Picks the source of one ALU operand; the nearer stage wins.
module hz_fwd_sel
  import hz_pkg::*;
#(
  parameter int AW = 5
) (
  input  logic          src_use,
  input  logic [AW-1:0] src,
  input  logic [AW-1:0] mem_rd,
  input  logic          mem_wen,
  input  logic [AW-1:0] wb_rd,
  input  logic          wb_wen,
  output fwd_src_e      sel
);
  always_comb begin
    sel = SRC_RF;
    if (src_use && src != '0) begin
      if (mem_wen && mem_rd == src)     sel = SRC_MEM;
      else if (wb_wen && wb_rd == src)  sel = SRC_WB;
    end
  end
endmodule

// File: rtl/hz_stall.sv
// Load-use bubble and branch wait.
module hz_stall #(
  parameter int AW = 5
) (
  input  logic          id_valid,
  input  logic          id_use1,
  input  logic          id_use2,
  input  logic [AW-1:0] id_rs1,
  input  logic [AW-1:0] id_rs2,
  input  logic          id_branch,
  input  logic          ex_valid,
  input  logic          ex_load,
  input  logic [AW-1:0] ex_rd,
  input  logic          ex_branch,
  output logic          pc_hold,
  output logic          ifid_hold,
  output logic          ifid_squash,
  output logic          idex_bubble
);
  logic load_use;
  logic br_wait;

  always_comb begin
    load_use = ex_valid && ex_load && (ex_rd != '0) && id_valid &&
               ((id_use1 && id_rs1 == ex_rd) || (id_use2 && id_rs2 == ex_rd));
    br_wait  = (id_valid && id_branch) || (ex_valid && ex_branch);
  end

  assign pc_hold     = load_use || br_wait;
  assign ifid_hold   = load_use;
  assign ifid_squash = br_wait && !load_use;
  assign idex_bubble = load_use;
endmodule

// File: rtl/hazard_ctrl.sv
module hazard_ctrl
  import hz_pkg::*;
#(
  parameter int AW = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          id_valid,
  input  logic [AW-1:0] id_rs1,
  input  logic [AW-1:0] id_rs2,
  input  logic          id_use_rs1,
  input  logic          id_use_rs2,
  input  logic [AW-1:0] id_rd,
  input  logic          id_wen,
  input  logic          id_load,
  input  logic          id_store,
  input  logic          id_branch,
  output logic [1:0]    ex_fwd_a,
  output logic [1:0]    ex_fwd_b,
  output logic          pc_hold,
  output logic          ifid_hold,
  output logic          ifid_squash,
  output logic          idex_bubble,
  output logic          mem_we,
  output logic          wb_wen,
  output logic [AW-1:0] wb_rd
);
  localparam int NSRC = 2;

  logic          ex_valid, ex_use1, ex_use2, ex_wen, ex_load, ex_store, ex_branch;
  logic [AW-1:0] ex_rs1, ex_rs2, ex_rd, mem_rd;
  logic          mem_wen, mem_load;

  hz_stall #(.AW(AW)) u_stall (
    .id_valid    (id_valid),
    .id_use1     (id_use_rs1),
    .id_use2     (id_use_rs2),
    .id_rs1      (id_rs1),
    .id_rs2      (id_rs2),
    .id_branch   (id_branch),
    .ex_valid    (ex_valid),
    .ex_load     (ex_load),
    .ex_rd       (ex_rd),
    .ex_branch   (ex_branch),
    .pc_hold     (pc_hold),
    .ifid_hold   (ifid_hold),
    .ifid_squash (ifid_squash),
    .idex_bubble (idex_bubble)
  );

  hz_ctl_pipe #(.AW(AW)) u_pipe (
    .clk       (clk),
    .rst_n     (rst_n),
    .bubble    (idex_bubble),
    .id_valid  (id_valid),
    .id_rs1    (id_rs1),
    .id_rs2    (id_rs2),
    .id_use1   (id_use_rs1),
    .id_use2   (id_use_rs2),
    .id_rd     (id_rd),
    .id_wen    (id_wen),
    .id_load   (id_load),
    .id_store  (id_store),
    .id_branch (id_branch),
    .ex_valid  (ex_valid),
    .ex_rs1    (ex_rs1),
    .ex_rs2    (ex_rs2),
    .ex_use1   (ex_use1),
    .ex_use2   (ex_use2),
    .ex_rd     (ex_rd),
    .ex_wen    (ex_wen),
    .ex_load   (ex_load),
    .ex_store  (ex_store),
    .ex_branch (ex_branch),
    .mem_rd    (mem_rd),
    .mem_wen   (mem_wen),
    .mem_load  (mem_load),
    .mem_store (mem_we),
    .wb_rd     (wb_rd),
    .wb_wen    (wb_wen)
  );

  logic [AW-1:0] src_reg [NSRC];
  logic          src_use [NSRC];
  fwd_src_e      src_sel [NSRC];

  assign src_reg[0] = ex_rs1;
  assign src_reg[1] = ex_rs2;
  assign src_use[0] = ex_use1;
  assign src_use[1] = ex_use2;

  for (genvar g = 0; g < NSRC; g++) begin : g_opnd
    hz_fwd_sel #(.AW(AW)) u_sel (
      .src_use (src_use[g]),
      .src     (src_reg[g]),
      .mem_rd  (mem_rd),
      .mem_wen (mem_wen),
      .wb_rd   (wb_rd),
      .wb_wen  (wb_wen),
      .sel     (src_sel[g])
    );
  end

  assign ex_fwd_a = src_sel[0];
  assign ex_fwd_b = src_sel[1];
endmodule

// File: rtl/hz_ctrl_chk.sv
module hz_ctrl_chk #(
  parameter int AW = 5
) (
  input logic          clk,
  input logic          rst_n,
  input logic [1:0]    ex_fwd_a,
  input logic [1:0]    ex_fwd_b,
  input logic [AW-1:0] ex_rs1,
  input logic [AW-1:0] ex_rs2,
  input logic          ex_valid,
  input logic          ex_wen,
  input logic          ex_store,
  input logic          ex_branch,
  input logic [AW-1:0] mem_rd,
  input logic          mem_wen,
  input logic          mem_load,
  input logic          wb_wen,
  input logic          mem_we,
  input logic          pc_hold,
  input logic          ifid_hold,
  input logic          ifid_squash,
  input logic          idex_bubble
);
  p_carry_r1: assert property (@(posedge clk) disable iff (!rst_n)
    mem_wen |=> wb_wen);
  p_near_wins_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (ex_fwd_a == 2'd1) |-> !(mem_wen && mem_rd == ex_rs1));
  p_zero_a_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (ex_rs1 == '0) |-> (ex_fwd_a == 2'd0));
  p_zero_b_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (ex_rs2 == '0) |-> (ex_fwd_b == 2'd0));
  p_one_bubble_r6: assert property (@(posedge clk) disable iff (!rst_n)
    idex_bubble |=> !idex_bubble);
  p_bubble_holds_r6: assert property (@(posedge clk) disable iff (!rst_n)
    idex_bubble |-> (pc_hold && ifid_hold));
  p_no_load_near_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ((ex_fwd_a == 2'd2) || (ex_fwd_b == 2'd2)) |-> !mem_load);
  p_bubble_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
    idex_bubble |=> (!ex_valid && !ex_wen && !ex_store));
  p_branch_wait_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (ex_valid && ex_branch) |-> (pc_hold && ifid_squash && !ifid_hold));
  p_hold_first_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !(ifid_hold && ifid_squash));
  p_reset_r11: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (!wb_wen && !mem_we));
endmodule

bind hazard_ctrl hz_ctrl_chk #(.AW(AW)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .ex_fwd_a    (ex_fwd_a),
  .ex_fwd_b    (ex_fwd_b),
  .ex_rs1      (ex_rs1),
  .ex_rs2      (ex_rs2),
  .ex_valid    (ex_valid),
  .ex_wen      (ex_wen),
  .ex_store    (ex_store),
  .ex_branch   (ex_branch),
  .mem_rd      (mem_rd),
  .mem_wen     (mem_wen),
  .mem_load    (mem_load),
  .wb_wen      (wb_wen),
  .mem_we      (mem_we),
  .pc_hold     (pc_hold),
  .ifid_hold   (ifid_hold),
  .ifid_squash (ifid_squash),
  .idex_bubble (idex_bubble)
);

// File: tb/hazard_ctrl_bench.sv
module hazard_ctrl_bench;
  localparam int AW = 5;

  logic clk = 1'b0;
  always #4 clk = ~clk;
  logic rst_n = 1'b0;

  typedef enum logic [1:0] {K_ALU = 2'd0, K_LD = 2'd1, K_ST = 2'd2, K_BR = 2'd3} kind_e;
  typedef struct packed {
    kind_e       k;
    logic [2:0]  rd;
    logic [2:0]  rs1;
    logic [2:0]  rs2;
    logic [15:0] imm;
  } ins_t;

  ins_t prog [64];
  int   n_ins = 0;
  int   n_checks = 0;
  int   n_fail = 0;

  logic          id_valid, id_use_rs1, id_use_rs2, id_wen, id_load, id_store, id_branch;
  logic [AW-1:0] id_rs1, id_rs2, id_rd, wb_rd;
  logic [1:0]    ex_fwd_a, ex_fwd_b;
  logic          pc_hold, ifid_hold, ifid_squash, idex_bubble, mem_we, wb_wen;

  hazard_ctrl #(.AW(AW)) u_hazard_ctrl (
    .clk(clk), .rst_n(rst_n), .id_valid(id_valid), .id_rs1(id_rs1), .id_rs2(id_rs2),
    .id_use_rs1(id_use_rs1), .id_use_rs2(id_use_rs2), .id_rd(id_rd), .id_wen(id_wen),
    .id_load(id_load), .id_store(id_store), .id_branch(id_branch),
    .ex_fwd_a(ex_fwd_a), .ex_fwd_b(ex_fwd_b), .pc_hold(pc_hold), .ifid_hold(ifid_hold),
    .ifid_squash(ifid_squash), .idex_bubble(idex_bubble), .mem_we(mem_we),
    .wb_wen(wb_wen), .wb_rd(wb_rd)
  );

  function automatic logic [31:0] memfn(input logic [31:0] x);
    return (x * 32'h9E3779B1) ^ 32'h00005A5A;
  endfunction
  function automatic bit writes(input kind_e k);
    return (k == K_ALU) || (k == K_LD);
  endfunction
  function automatic bit uses2(input kind_e k);
    return k != K_LD;
  endfunction

  // register-level data path model driven by the controller outputs
  logic [31:0] rf [8];
  int          pc;
  logic        f_v;
  int          f_idx;
  logic        x_v;
  ins_t        x_i;
  logic [31:0] x_a, x_b;
  logic        m_v, m_wen, m_ld, m_st;
  logic [2:0]  m_rd;
  logic [31:0] m_res;
  logic        w_v, w_wen;
  logic [2:0]  w_rd;
  logic [31:0] w_val;
  int          retired, n_bub, n_sq, n_st, n_mem, n_wb, n_mis;

  ins_t di;
  assign di         = prog[f_idx[5:0]];
  assign id_valid   = f_v;
  assign id_rs1     = f_v ? {2'b00, di.rs1} : '0;
  assign id_rs2     = f_v ? {2'b00, di.rs2} : '0;
  assign id_rd      = f_v ? {2'b00, di.rd}  : '0;
  assign id_use_rs1 = f_v;
  assign id_use_rs2 = f_v && uses2(di.k);
  assign id_wen     = f_v && writes(di.k);
  assign id_load    = f_v && di.k == K_LD;
  assign id_store   = f_v && di.k == K_ST;
  assign id_branch  = f_v && di.k == K_BR;

  function automatic logic [31:0] rdv(input logic [2:0] r);
    if (r == 3'd0) return 32'd0;
    if (w_v && w_wen && w_rd == r) return w_val;  // write-first register file
    return rf[r];
  endfunction
  function automatic logic [31:0] pick(input logic [1:0] s, input logic [31:0] v);
    if (s == 2'd2) return m_res;
    if (s == 2'd1) return w_val;
    return v;
  endfunction

  always @(posedge clk) begin : model
    logic [31:0] a, b, r;
    if (!rst_n) begin
      for (int i = 0; i < 8; i++) rf[i] <= 32'h111 * i;
      pc <= 0; f_v <= 1'b0; f_idx <= 0; x_v <= 1'b0; x_i <= '0; x_a <= '0; x_b <= '0;
      m_v <= 1'b0; m_wen <= 1'b0; m_ld <= 1'b0; m_st <= 1'b0; m_rd <= '0; m_res <= '0;
      w_v <= 1'b0; w_wen <= 1'b0; w_rd <= '0; w_val <= '0;
      retired <= 0; n_bub <= 0; n_sq <= 0; n_st <= 0; n_mem <= 0; n_wb <= 0; n_mis <= 0;
    end else begin
      if (w_v && w_wen && w_rd != 3'd0) rf[w_rd] <= w_val;
      if (w_v) retired <= retired + 1;
      w_v <= m_v; w_wen <= m_wen; w_rd <= m_rd;
      w_val <= m_ld ? memfn(m_res) : m_res;
      a = pick(ex_fwd_a, x_a);
      b = pick(ex_fwd_b, x_b);
      case (x_i.k)
        K_ALU:   r = a + b + {16'd0, x_i.imm};
        K_LD:    r = a + {16'd0, x_i.imm};
        default: r = 32'd0;
      endcase
      m_v <= x_v; m_wen <= x_v && writes(x_i.k); m_ld <= x_v && x_i.k == K_LD;
      m_st <= x_v && x_i.k == K_ST; m_rd <= x_i.rd; m_res <= r;
      if (idex_bubble || !f_v) begin
        x_v <= 1'b0; x_i <= '0;
      end else begin
        x_v <= 1'b1; x_i <= di; x_a <= rdv(di.rs1); x_b <= rdv(di.rs2);
      end
      if (!ifid_hold) begin
        if (ifid_squash || pc >= n_ins) f_v <= 1'b0;
        else begin f_v <= 1'b1; f_idx <= pc; end
      end
      if (!pc_hold && pc < n_ins) pc <= pc + 1;
      n_bub <= n_bub + int'(idex_bubble);
      n_sq  <= n_sq + int'(ifid_squash);
      n_st  <= n_st + int'(mem_we);
      n_mem <= n_mem + int'(ex_fwd_a == 2'd2) + int'(ex_fwd_b == 2'd2);
      n_wb  <= n_wb + int'(ex_fwd_a == 2'd1) + int'(ex_fwd_b == 2'd1);
      if ((mem_we !== m_st) || (wb_wen !== (w_v && w_wen)) || (wb_wen && wb_rd != {2'b00, w_rd}))
        n_mis <= n_mis + 1;
    end
  end

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic ins_t mk(input kind_e k, input int rd, input int rs1, input int rs2, input int imm);
    ins_t t;
    t.k = k; t.rd = rd[2:0]; t.rs1 = rs1[2:0]; t.rs2 = rs2[2:0]; t.imm = imm[15:0];
    return t;
  endfunction

  task automatic run(input string name, input string rtag, input int e_mem, input int e_wb);
    logic [31:0] rr [8];
    int lu, brf, brt, st, cyc, exp_cyc, bad;
    for (int i = 0; i < 8; i++) rr[i] = 32'h111 * i;
    lu = 0; brf = 0; brt = 0; st = 0;
    for (int i = 0; i < n_ins; i++) begin
      ins_t t = prog[i];
      logic [31:0] a = rr[t.rs1], b = rr[t.rs2];
      if (t.k == K_ALU && t.rd != 0) rr[t.rd] = a + b + {16'd0, t.imm};
      if (t.k == K_LD  && t.rd != 0) rr[t.rd] = memfn(a + {16'd0, t.imm});
      if (t.k == K_ST) st++;
      if (t.k == K_BR) begin brt++; if (i < n_ins - 1) brf++; end
      if (t.k == K_LD && t.rd != 0 && i < n_ins - 1)
        if (prog[i+1].rs1 == t.rd || (uses2(prog[i+1].k) && prog[i+1].rs2 == t.rd)) lu++;
    end
    exp_cyc = n_ins + 4 + lu + 2 * brf;
    rst_n = 1'b0;
    repeat (2) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    cyc = 0;
    while (retired < n_ins && cyc < 2000) begin
      @(posedge clk); #1; cyc++;
    end
    check(cyc == exp_cyc, "R10", {name, " retire cycles"}, cyc, exp_cyc);
    bad = -1;
    for (int i = 7; i >= 0; i--) if (rf[i] !== rr[i]) bad = i;
    check(bad < 0, rtag, {name, " register file vs sequential"},
          bad < 0 ? 0 : rf[bad], bad < 0 ? 0 : rr[bad]);
    check(n_bub == lu, "R6", {name, " bubble count"}, n_bub, lu);
    check(n_sq == 2 * brt, "R8", {name, " squash count"}, n_sq, 2 * brt);
    check(n_st == st, "R7", {name, " store count"}, n_st, st);
    check(n_mis == 0, "R1", {name, " late-stage control mismatches"}, n_mis, 0);
    if (e_mem >= 0) check(n_mem == e_mem, "R2", {name, " near-stage selects"}, n_mem, e_mem);
    if (e_wb >= 0)  check(n_wb == e_wb, "R3", {name, " far-stage selects"}, n_wb, e_wb);
  endtask

  initial begin : watchdog
    #(8 * 150000);
    n_checks++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    void'($urandom(32'd2718));
    // R11 reset state
    repeat (2) @(posedge clk);
    @(negedge clk);
    check({pc_hold, ifid_hold, ifid_squash, idex_bubble, mem_we, wb_wen} == 6'd0 &&
          ex_fwd_a == 2'd0 && ex_fwd_b == 2'd0, "R11", "outputs in reset",
          {pc_hold, ifid_hold, ifid_squash, idex_bubble, mem_we, wb_wen}, 0);

    // R2 R3 R4: priority of the nearer producer, far select, write-first read
    n_ins = 5;
    prog[0] = mk(K_ALU, 1, 0, 0, 5);
    prog[1] = mk(K_ALU, 1, 0, 0, 7);
    prog[2] = mk(K_ALU, 2, 1, 1, 0);
    prog[3] = mk(K_ALU, 3, 2, 1, 0);
    prog[4] = mk(K_ALU, 4, 1, 3, 0);
    run("priority", "R4", 4, 1);

    // R5 register 0
    n_ins = 4;
    prog[0] = mk(K_ALU, 0, 0, 0, 9);
    prog[1] = mk(K_ALU, 1, 0, 0, 3);
    prog[2] = mk(K_LD,  0, 1, 0, 0);
    prog[3] = mk(K_ALU, 2, 0, 0, 1);
    run("reg0", "R5", 1, 0);

    // R6 R7 load-use and store
    n_ins = 6;
    prog[0] = mk(K_LD,  3, 2, 0, 4);
    prog[1] = mk(K_ALU, 4, 3, 1, 0);
    prog[2] = mk(K_LD,  5, 4, 0, 0);
    prog[3] = mk(K_ALU, 6, 1, 1, 0);
    prog[4] = mk(K_ALU, 7, 5, 6, 0);
    prog[5] = mk(K_ST,  0, 7, 3, 0);
    run("loaduse", "R6", 3, 2);

    // R8 R9 branches, one behind a load
    n_ins = 5;
    prog[0] = mk(K_LD,  2, 1, 0, 0);
    prog[1] = mk(K_BR,  0, 2, 0, 0);
    prog[2] = mk(K_ALU, 3, 2, 1, 0);
    prog[3] = mk(K_BR,  0, 3, 3, 0);
    prog[4] = mk(K_ALU, 4, 3, 3, 0);
    run("branch", "R9", -1, -1);
    check(n_sq == 4, "R9", "squash with coinciding hold", n_sq, 4);

    // random programs
    for (int p = 0; p < 6; p++) begin
      n_ins = 40;
      for (int i = 0; i < n_ins; i++) begin
        int sel = $urandom % 10;
        kind_e k = (sel < 5 || sel == 9) ? K_ALU : (sel < 7) ? K_LD : (sel == 7) ? K_ST : K_BR;
        prog[i] = mk(k, $urandom % 8, $urandom % 8, $urandom % 8, $urandom % 65536);
      end
      run($sformatf("random%0d", p), "R10", -1, -1);
    end

    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule